// File: doc/BRIEF.md
# Inter-Core Attention Hub with Source Tracking

The hub carries attention signals among a group of cores (sixteen by default). In any cycle any core may raise a send request with a destination mask. Each destination then gets a sticky event flag, and also a source register with one bit for each core that signalled it. Because of the source register, a receiving core knows which peers want its attention and does not have to query each of them. Without it, the core would see only that someone did.

A receiving core uses its flag in one of three ways. It can poll it, which returns the flag and consumes it. It can wait on it, which stalls until the flag is set and then consumes it. It can take it as an interrupt request: a one-cycle pulse marks the flag rising. The core reads its source register from the output bus. It clears the register with a single strobe, and that strobe never loses a request that arrives in the same cycle. The core pipelines that issue these commands, and any interrupt vectoring, sit outside this block.

Top module: `attn_hub`

## Requirements
- R1: After reset every source register, every event flag and every interrupt pulse is zero.
- R2: Core s sends by asserting sendValid[s]. Bit d of its mask, sendMask[s*N+d], selects destination core d. If d differs from s, bit s of core d's source register, srcBits[d*N+s], is 1 from the cycle after the send.
- R3: A core's mask bit for itself is ignored, so srcBits[d*N+d] is always 0.
- R4: Source bits are sticky. They accumulate across sends from different cores and over time until the receiver clears them.
- R5: A high rdClr[d] empties core d's source register at the next edge. Any request arriving for d in that same cycle still leaves its bit set.
- R6: eventFlag[d] is 1 from the cycle after any request reaches core d. It stays 1 until a poll, a completed wait or a clear consumes it, and a consumption in a cycle with a new arrival leaves it set.
- R7: pollHit[d] equals eventFlag[d] in any cycle with pollReq[d] high. The flag is cleared at that edge unless a request arrives in the same cycle.
- R8: waitStall[d] is high while waitReq[d] is high and eventFlag[d] is low. When waitReq[d] meets a set flag, the flag is consumed as for a poll.
- R9: irqReq[d] is high for exactly the first cycle of each interval in which eventFlag[d] is high.
- R10: eventFlag[d] is never 1 while core d's source register is zero. A clear with no arrival also drops the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sendValid | input | N | Per-core send request |
| sendMask | input | N*N | Destination masks, core s at bits [s*N +: N] |
| rdClr | input | N | Per-core clear of its source register |
| pollReq | input | N | Per-core poll of the event flag |
| waitReq | input | N | Per-core wait on the event flag |
| srcBits | output | N*N | Source registers, core d at bits [d*N +: N] |
| eventFlag | output | N | Per-core event flag |
| pollHit | output | N | Poll result, valid while pollReq is high |
| waitStall | output | N | Stall for a core waiting on a clear flag |
| irqReq | output | N | One-cycle interrupt pulse when the flag rises |

## Verification
The assertions assume only that every input is driven to a known value after reset is released. They allow any mix of sends, polls, waits and clears to any core, including in the same cycle. The stimulus is a set of directed cases followed by random traffic. The directed cases cover self-addressed masks, a clear colliding with an arrival, and polls and waits meeting set and clear flags. The random traffic is sparse enough that flags often drop to zero and rise again, which exercises the interrupt pulse.

// File: rtl/attn_pkg.sv
package attn_pkg;
  // Control-to-datapath strobes for one receiving core
  typedef struct packed {
    logic clrSrc;       // empty the source register
    logic consumeFlag;  // poll or satisfied wait consumes the event
  } attnStrobe_t;
endpackage

// File: rtl/attn_ctrl.sv
module attn_ctrl
  import attn_pkg::*;
#(
  parameter int NUM_CORES = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CORES-1:0]    pollReq,
  input  logic [NUM_CORES-1:0]    waitReq,
  input  logic [NUM_CORES-1:0]    rdClr,
  input  logic [NUM_CORES-1:0]    eventFlag,
  output attnStrobe_t [NUM_CORES-1:0] strobes,
  output logic [NUM_CORES-1:0]    pollHit,
  output logic [NUM_CORES-1:0]    waitStall
);
  for (genvar d = 0; d < NUM_CORES; d++) begin : g_core
    logic waitMet;
    assign waitMet              = waitReq[d] & eventFlag[d];
    assign pollHit[d]           = pollReq[d] & eventFlag[d];
    assign waitStall[d]         = waitReq[d] & ~eventFlag[d];
    assign strobes[d].consumeFlag = pollReq[d] | waitMet;
    assign strobes[d].clrSrc    = rdClr[d];

    // R8: a stalled core never consumes through its wait
    p_stall_no_consume_r8: assert property (@(posedge clk) disable iff (!rstN)
      (waitStall[d] && !pollReq[d]) |-> !strobes[d].consumeFlag);
    // R7: a poll hit always consumes
    p_hit_consumes_r7: assert property (@(posedge clk) disable iff (!rstN)
      pollHit[d] |-> strobes[d].consumeFlag);
  end
endmodule

// File: rtl/attn_datapath.sv
module attn_datapath
  import attn_pkg::*;
#(
  parameter int NUM_CORES = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CORES-1:0]        sendValid,
  input  logic [NUM_CORES*NUM_CORES-1:0] sendMask,
  input  attnStrobe_t [NUM_CORES-1:0] strobes,
  output logic [NUM_CORES*NUM_CORES-1:0] srcBits,
  output logic [NUM_CORES-1:0]        eventFlag,
  output logic [NUM_CORES-1:0]        irqReq
);
  localparam int N = NUM_CORES;

  logic [N-1:0] incMatrix [N];   // [dest][source]
  logic [N-1:0] srcQ [N];
  logic [N-1:0] flagQ, flagNext, irqQ, hasInc;

  // Request fan-out: transpose masks, drop self-addressed bits
  for (genvar d = 0; d < N; d++) begin : g_dst
    for (genvar s = 0; s < N; s++) begin : g_src
      if (s == d) begin : g_self
        assign incMatrix[d][s] = 1'b0;
      end else begin : g_peer
        assign incMatrix[d][s] = sendValid[s] & sendMask[s*N+d];
      end
    end
    assign hasInc[d]          = |incMatrix[d];
    assign srcBits[d*N +: N]  = srcQ[d];
  end

  always_comb begin
    for (int d = 0; d < N; d++) begin
      flagNext[d] = hasInc[d] |
                    (flagQ[d] & ~strobes[d].consumeFlag & ~strobes[d].clrSrc);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int d = 0; d < N; d++) srcQ[d] <= '0;
      flagQ <= '0;
      irqQ  <= '0;
    end else begin
      for (int d = 0; d < N; d++) begin
        srcQ[d] <= (strobes[d].clrSrc ? '0 : srcQ[d]) | incMatrix[d];
      end
      flagQ <= flagNext;
      irqQ  <= flagNext & ~flagQ;
    end
  end

  assign eventFlag = flagQ;
  assign irqReq    = irqQ;

  for (genvar d = 0; d < N; d++) begin : g_chk
    p_flag_needs_src_r10: assert property (@(posedge clk) disable iff (!rstN)
      flagQ[d] |-> (srcQ[d] != '0));
    p_no_self_r3: assert property (@(posedge clk) disable iff (!rstN)
      !srcQ[d][d]);
    p_arrival_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
      (incMatrix[d] != '0) |=>
        (((srcQ[d] & $past(incMatrix[d])) == $past(incMatrix[d])) && flagQ[d]));
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
      !strobes[d].clrSrc |=> ((srcQ[d] & $past(srcQ[d])) == $past(srcQ[d])));
    p_consume_r7: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[d].consumeFlag && incMatrix[d] == '0) |=> !flagQ[d]);
    p_irq_edge_r9: assert property (@(posedge clk) disable iff (!rstN)
      irqQ[d] |-> (flagQ[d] && !$past(flagQ[d])));
  end
endmodule

// File: rtl/attn_hub.sv
module attn_hub
  import attn_pkg::*;
#(
  parameter int NUM_CORES = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CORES-1:0]           sendValid,
  input  logic [NUM_CORES*NUM_CORES-1:0] sendMask,
  input  logic [NUM_CORES-1:0]           rdClr,
  input  logic [NUM_CORES-1:0]           pollReq,
  input  logic [NUM_CORES-1:0]           waitReq,
  output logic [NUM_CORES*NUM_CORES-1:0] srcBits,
  output logic [NUM_CORES-1:0]           eventFlag,
  output logic [NUM_CORES-1:0]           pollHit,
  output logic [NUM_CORES-1:0]           waitStall,
  output logic [NUM_CORES-1:0]           irqReq
);
  attnStrobe_t [NUM_CORES-1:0] strobes;

  attn_ctrl #(.NUM_CORES(NUM_CORES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .pollReq(pollReq), .waitReq(waitReq), .rdClr(rdClr),
    .eventFlag(eventFlag), .strobes(strobes),
    .pollHit(pollHit), .waitStall(waitStall)
  );

  attn_datapath #(.NUM_CORES(NUM_CORES)) u_dp (
    .clk(clk), .rstN(rstN),
    .sendValid(sendValid), .sendMask(sendMask), .strobes(strobes),
    .srcBits(srcBits), .eventFlag(eventFlag), .irqReq(irqReq)
  );
endmodule

// File: tb/attn_hub_bench.sv
`timescale 1ns/1ps
module attn_hub_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0]   sendValid = '0, rdClr = '0, pollReq = '0, waitReq = '0;
  logic [N*N-1:0] sendMask = '0;
  logic [N*N-1:0] srcBits;
  logic [N-1:0]   eventFlag, pollHit, waitStall, irqReq;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  logic [N-1:0] mSrc [N];
  logic [N-1:0] mFlag, mIrq;

  always #2 clk = ~clk;

  attn_hub #(.NUM_CORES(N)) u_attn_hub (
    .clk(clk), .rstN(rstN), .sendValid(sendValid), .sendMask(sendMask),
    .rdClr(rdClr), .pollReq(pollReq), .waitReq(waitReq),
    .srcBits(srcBits), .eventFlag(eventFlag), .pollHit(pollHit),
    .waitStall(waitStall), .irqReq(irqReq)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    for (int d = 0; d < N; d++) begin
      check("R4", $sformatf("srcBits core %0d", d), srcBits[d*N +: N], mSrc[d]);
      check("R6", $sformatf("eventFlag core %0d", d), eventFlag[d], mFlag[d]);
      check("R9", $sformatf("irqReq core %0d", d), irqReq[d], mIrq[d]);
      check("R7", $sformatf("pollHit core %0d", d), pollHit[d], pollReq[d] && mFlag[d]);
      check("R8", $sformatf("waitStall core %0d", d), waitStall[d], waitReq[d] && !mFlag[d]);
    end
  endtask

  task automatic advanceModel();
    for (int d = 0; d < N; d++) begin
      logic [N-1:0] arrive;
      logic consume, nf;
      arrive = '0;
      for (int s = 0; s < N; s++)
        if (s != d && sendValid[s] && sendMask[s*N+d]) arrive[s] = 1'b1;
      consume = pollReq[d] || (waitReq[d] && mFlag[d]);
      nf = (arrive != '0) || (mFlag[d] && !consume && !rdClr[d]);
      mSrc[d] = (rdClr[d] ? '0 : mSrc[d]) | arrive;
      mIrq[d] = nf && !mFlag[d];
      mFlag[d] = nf;
    end
  endtask

  task automatic runCycle(input logic [N-1:0] sv, input logic [N*N-1:0] sm,
                          input logic [N-1:0] pl, input logic [N-1:0] wt,
                          input logic [N-1:0] cl);
    @(negedge clk);
    sendValid = sv; sendMask = sm; pollReq = pl; waitReq = wt; rdClr = cl;
    #1;
    compareAll();
    advanceModel();
  endtask

  task automatic idle();
    runCycle('0, '0, '0, '0, '0);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N*N-1:0] sm;
    for (int d = 0; d < N; d++) mSrc[d] = '0;
    mFlag = '0; mIrq = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "srcBits", (srcBits == '0), 1);
    check("R1", "eventFlag", eventFlag, 0);
    check("R1", "irqReq", irqReq, 0);
    rstN = 1'b1;

    // R2 and R3: core 3 targets core 5 and itself
    sm = '0; sm[3*N+5] = 1'b1; sm[3*N+3] = 1'b1;
    runCycle(16'h0008, sm, '0, '0, '0);
    idle();
    check("R2", "core5 bit3", srcBits[5*N+3], 1);
    check("R3", "core3 self", srcBits[3*N +: N], 0);
    check("R9", "core5 irq pulse", irqReq[5], 1);

    // R5: core 7 targets core 5 while core 5 clears
    sm = '0; sm[7*N+5] = 1'b1;
    runCycle(16'h0080, sm, '0, '0, 16'h0020);
    idle();
    check("R5", "core5 after clear+arrival", srcBits[5*N +: N], 16'h0080);

    // R10: clear alone drops register and flag
    runCycle('0, '0, '0, '0, 16'h0020);
    idle();
    check("R10", "core5 src", srcBits[5*N +: N], 0);
    check("R10", "core5 flag", eventFlag[5], 0);

    // R7 poll consumes flag, R4 source kept
    sm = '0; sm[9*N+2] = 1'b1;
    runCycle(16'h0200, sm, '0, '0, '0);
    runCycle('0, '0, 16'h0004, '0, '0);
    check("R7", "core2 poll hit", pollHit[2], 1);
    idle();
    check("R7", "core2 flag after poll", eventFlag[2], 0);
    check("R4", "core2 src kept", srcBits[2*N+9], 1);

    // R8 wait stalls, then is satisfied
    runCycle('0, '0, '0, 16'h0010, '0);
    check("R8", "core4 stall", waitStall[4], 1);
    sm = '0; sm[1*N+4] = 1'b1;
    runCycle(16'h0002, sm, '0, 16'h0010, '0);
    runCycle('0, '0, '0, 16'h0010, '0);
    check("R8", "core4 released", waitStall[4], 0);
    idle();
    check("R8", "core4 flag consumed", eventFlag[4], 0);

    // R6 sticky flag, multi-source accumulation
    sm = '0; sm[0*N+6] = 1'b1; sm[10*N+6] = 1'b1;
    runCycle(16'h0401, sm, '0, '0, '0);
    idle(); idle();
    check("R6", "core6 flag held", eventFlag[6], 1);
    check("R4", "core6 sources", srcBits[6*N +: N], 16'h0401);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] sv, pl, wt, cl;
      logic [N*N-1:0] rm;
      sv = '0; pl = '0; wt = '0; cl = '0; rm = '0;
      for (int c = 0; c < N; c++) begin
        sv[c] = ($urandom_range(7) == 0);
        pl[c] = ($urandom_range(7) == 0);
        wt[c] = ($urandom_range(3) == 0);
        cl[c] = ($urandom_range(9) == 0);
        for (int b = 0; b < N; b++) rm[c*N+b] = ($urandom_range(5) == 0);
      end
      runCycle(sv, rm, pl, wt, cl);
    end
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule